// File: doc/BRIEF.md
# Vector Element Zip Permute Unit

This unit interleaves elements taken from one half of two source vectors into a destination vector of the same length. The element width is chosen per operation: 8, 16, 32 or 64 bits through a two-bit size field, or 128 bits through a separate wide-element input that overrides the size field. A half-select input picks whether the source elements come from the lower half or the upper half of both sources. Element `p` of the chosen half of the first source lands in destination slot `2p`, and the matching element of the second source lands in slot `2p+1`.

The vector length `VLEN` is fixed when the unit is built. Each operation enters with a one-cycle request strobe, and its result appears one clock later with a valid strobe. Some element widths are too large for the vector length. For those the unit reports an undefined-operation strobe and produces no result.

Top module: `vec_zip_unit`

## Requirements
- R1: With `upperHalf`=0, for every pair index p below PAIRS = VLEN/(2·E), destination element 2p equals element p of `srcA`, and destination element 2p+1 equals element p of `srcB`. Element k occupies bits [k·E +: E].
- R2: With `upperHalf`=1 the source index becomes PAIRS+p. Destination element 2p equals `srcA` element PAIRS+p, and destination element 2p+1 equals `srcB` element PAIRS+p.
- R3: With `qMode`=0 the size field selects E: `sizeSel` 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64.
- R4: With `qMode`=1, E is 128 bits whatever the value of `sizeSel`.
- R5: A legal request (`inValid`=1) drives `outValid` high on the next clock, with the new `result`. `outValid` is low in every cycle that does not follow a legal request.
- R6: A request whose E·2 exceeds VLEN (this happens only in 128-bit mode with VLEN=128) drives `outUndef` high on the next clock. In that cycle `outValid` stays low and `result` keeps its previous value.
- R7: When `rstN` is low at a clock edge, `outValid`, `outUndef` and `result` are cleared to zero.
- R8: In cycles without a legal request, `result` holds its value.
- R9: VLEN must be a power of two from 128 to 2048. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Request strobe, one cycle per operation |
| sizeSel | input | 2 | Element size code (R3) |
| qMode | input | 1 | Selects 128-bit elements and overrides sizeSel |
| upperHalf | input | 1 | 0: take elements from the lower halves; 1: from the upper halves |
| srcA | input | VLEN | First source vector; its elements fill the even destination slots |
| srcB | input | VLEN | Second source vector; its elements fill the odd destination slots |
| outValid | output | 1 | Result valid, one cycle after a legal request |
| outUndef | output | 1 | Undefined-operation strobe, one cycle after an illegal request |
| result | output | VLEN | Interleaved destination vector |

## Verification
The undefined case cannot occur at the default VLEN of 256, because every element width fits there. The bench therefore builds a second copy of the unit with VLEN=128 and sends both copies the same stimulus. Every 128-bit-mode vector in the stimulus table then exercises the illegal path on the small copy, while the large copy returns a legal 128-bit zip. The small copy already holds a known result from a previous operation, which makes it visible if that result is overwritten. Each row of the table pairs one element size with one half and with operands built from seeds. Every row is compared against a loop model that is independent of the RTL.

// File: rtl/zip_pkg.sv
package zip_pkg;
  localparam int NUM_SIZES = 5;

  typedef struct packed {
    logic       load;
    logic       undef;
    logic       upper;
    logic [2:0] eidx;
  } zip_strobe_t;

  function automatic int elem_bits(input logic [2:0] idx);
    return 8 << idx;
  endfunction
endpackage

// File: rtl/zip_ctrl.sv
module zip_ctrl #(
  parameter int VLEN = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          sizeSel,
  input  logic                qMode,
  input  logic                upperHalf,
  output zip_pkg::zip_strobe_t strobe,
  output logic                outValid,
  output logic                outUndef
);
  logic [2:0] eidx;
  logic       tooWide;

  always_comb begin
    eidx    = qMode ? 3'd4 : {1'b0, sizeSel};
    tooWide = (2 * zip_pkg::elem_bits(eidx)) > VLEN;
    strobe.eidx  = eidx;
    strobe.upper = upperHalf;
    strobe.undef = inValid && tooWide;
    strobe.load  = inValid && !tooWide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outUndef <= 1'b0;
    end else begin
      outValid <= strobe.load;
      outUndef <= strobe.undef;
    end
  end

  a_r5_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !outUndef));
  a_r6_undef_excludes_valid: assert property (@(posedge clk) disable iff (!rstN)
    outUndef |-> !outValid);
  a_r4_q_small_undef: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && qMode && VLEN < 256) |=> outUndef);
endmodule

// File: rtl/zip_datapath.sv
module zip_datapath #(
  parameter int VLEN = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  zip_pkg::zip_strobe_t strobe,
  input  logic [VLEN-1:0]      srcA,
  input  logic [VLEN-1:0]      srcB,
  output logic [VLEN-1:0]      result
);
  localparam int NS = zip_pkg::NUM_SIZES;

  logic [NS-1:0][VLEN-1:0] cand;
  logic [VLEN-1:0]         nextRes;

  for (genvar k = 0; k < NS; k++) begin : g_size
    localparam int ESZ   = 8 << k;
    localparam int PAIRS = VLEN / (2 * ESZ);
    if (2 * ESZ <= VLEN) begin : g_fit
      logic [VLEN-1:0] lane;
      always_comb begin
        lane = '0;
        for (int p = 0; p < PAIRS; p++) begin
          if (strobe.upper) begin
            lane[2*p*ESZ +: ESZ]     = srcA[(PAIRS+p)*ESZ +: ESZ];
            lane[(2*p+1)*ESZ +: ESZ] = srcB[(PAIRS+p)*ESZ +: ESZ];
          end else begin
            lane[2*p*ESZ +: ESZ]     = srcA[p*ESZ +: ESZ];
            lane[(2*p+1)*ESZ +: ESZ] = srcB[p*ESZ +: ESZ];
          end
        end
      end
      assign cand[k] = lane;
    end else begin : g_nofit
      assign cand[k] = '0;
    end
  end

  always_comb begin
    nextRes = '0;
    for (int k = 0; k < NS; k++)
      if (strobe.eidx == 3'(k)) nextRes = cand[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            result <= '0;
    else if (strobe.load) result <= nextRes;
  end

  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(result));
  a_r1_low_first_elem: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.upper) |=> result[7:0] == $past(srcA[7:0]));
  a_r2_high_first_elem: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.upper) |=> result[7:0] == $past(srcA[VLEN/2 +: 8]));
endmodule

// File: rtl/vec_zip_unit.sv
module vec_zip_unit #(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      sizeSel,
  input  logic            qMode,
  input  logic            upperHalf,
  input  logic [VLEN-1:0] srcA,
  input  logic [VLEN-1:0] srcB,
  output logic            outValid,
  output logic            outUndef,
  output logic [VLEN-1:0] result
);
  // R9: legal vector lengths only
  if (VLEN < 128 || VLEN > 2048 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
    $error("vec_zip_unit: VLEN must be a power of two in 128..2048");
  end

  zip_pkg::zip_strobe_t strobe;

  zip_ctrl #(.VLEN(VLEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeSel(sizeSel),
    .qMode(qMode), .upperHalf(upperHalf), .strobe(strobe),
    .outValid(outValid), .outUndef(outUndef)
  );

  zip_datapath #(.VLEN(VLEN)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcA(srcA), .srcB(srcB), .result(result)
  );
endmodule

// File: tb/vec_zip_unit_bench.sv
module vec_zip_unit_bench;
  localparam int VL  = 256;
  localparam int VLS = 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [1:0]    sizeSel = 2'b00;
  logic          qMode = 1'b0;
  logic          upperHalf = 1'b0;
  logic [VL-1:0] srcA = '0, srcB = '0;
  logic          outValid, outUndef, outValidS, outUndefS;
  logic [VL-1:0]  result;
  logic [VLS-1:0] resultS;

  vec_zip_unit #(.VLEN(VL)) u_vec_zip_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeSel(sizeSel), .qMode(qMode),
    .upperHalf(upperHalf), .srcA(srcA), .srcB(srcB),
    .outValid(outValid), .outUndef(outUndef), .result(result));

  vec_zip_unit #(.VLEN(VLS)) u_vec_zip_unit_small (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeSel(sizeSel), .qMode(qMode),
    .upperHalf(upperHalf), .srcA(srcA[VLS-1:0]), .srcB(srcB[VLS-1:0]),
    .outValid(outValidS), .outUndef(outUndefS), .result(resultS));

  int nChecks = 0, nFails = 0, cycles = 0;

  typedef struct packed {
    logic [1:0]  sz;
    logic        q;
    logic        up;
    logic [31:0] seedA;
    logic [31:0] seedB;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TABLE [NV] = '{
    '{2'b00, 1'b0, 1'b0, 32'h0000_0011, 32'h0000_0022},  // R3 8-bit low
    '{2'b00, 1'b0, 1'b1, 32'h0000_1234, 32'h0000_5678},  // R3 8-bit high
    '{2'b01, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D},
    '{2'b01, 1'b0, 1'b1, 32'h0BAD_F00D, 32'h1357_9BDF},
    '{2'b10, 1'b1, 1'b0, 32'h2468_ACE0, 32'h0F0F_0F0F},  // R4 q overrides
    '{2'b10, 1'b0, 1'b0, 32'hA5A5_5A5A, 32'h3C3C_C3C3},
    '{2'b10, 1'b0, 1'b1, 32'h7777_1111, 32'h8888_2222},
    '{2'b11, 1'b0, 1'b0, 32'h1111_2222, 32'h3333_4444},
    '{2'b11, 1'b0, 1'b1, 32'h5555_6666, 32'h7777_8888},
    '{2'b00, 1'b1, 1'b1, 32'h9999_AAAA, 32'hBBBB_CCCC},  // R4 q high
    '{2'b11, 1'b1, 1'b0, 32'hFEDC_BA98, 32'h0123_4567},
    '{2'b01, 1'b0, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF},
    '{2'b00, 1'b0, 1'b1, 32'h4242_4242, 32'h1010_1010},
    '{2'b11, 1'b1, 1'b1, 32'h6060_0606, 32'h7171_1717}
  };

  function automatic logic [VL-1:0] genVec(input logic [31:0] seed);
    logic [31:0] w;
    genVec = '0;
    for (int i = 0; i < VL / 32; i++) begin
      w = seed * 32'h9E37_79B1 + 32'(i) * 32'h7F4A_7C15;
      w = w ^ (w >> 15) ^ (w << 7);
      genVec[i*32 +: 32] = w;
    end
  endfunction

  function automatic logic [VL-1:0] model(input logic [VL-1:0] a, input logic [VL-1:0] b,
                                          input int vl, input int esz, input logic up);
    int pairs = vl / (2 * esz);
    int base  = up ? pairs : 0;
    model = '0;
    for (int p = 0; p < pairs; p++)
      for (int bt = 0; bt < esz; bt++) begin
        model[2*p*esz + bt]     = a[(base+p)*esz + bt];
        model[(2*p+1)*esz + bt] = b[(base+p)*esz + bt];
      end
  endfunction

  task automatic check(input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] sz, input logic q, input logic up,
                       input logic [VL-1:0] a, input logic [VL-1:0] b);
    @(negedge clk);
    sizeSel = sz; qMode = q; upperHalf = up; srcA = a; srcB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog actual %0d expected <100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [VL-1:0]  a, b, expB, expS;
    logic [VLS-1:0] prevS;
    int esz;

    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 outValid", VL'(outValid), '0);
    check("R7 outUndef", VL'(outUndef), '0);
    check("R7 result", result, '0);
    check("R7 resultS", VL'(resultS), '0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      a = genVec(TABLE[i].seedA);
      b = genVec(TABLE[i].seedB);
      esz = TABLE[i].q ? 128 : (8 << TABLE[i].sz);
      prevS = resultS;
      issue(TABLE[i].sz, TABLE[i].q, TABLE[i].up, a, b);
      expB = model(a, b, VL, esz, TABLE[i].up);
      check(TABLE[i].up ? "R2 result" : "R1 result", result, expB);
      check("R5 outValid", VL'(outValid), VL'(1'b1));
      if (TABLE[i].q) begin
        check("R6 small outUndef", VL'(outUndefS), VL'(1'b1));
        check("R6 small outValid", VL'(outValidS), '0);
        check("R6 small result held", VL'(resultS), VL'(prevS));
      end else begin
        expS = model(a, b, VLS, esz, TABLE[i].up);
        check("R3 small result", VL'(resultS), expS);
        check("R6 small no undef", VL'(outUndefS), '0);
      end
    end

    // R8 / R5: idle cycles hold result and drop valid
    expB = result;
    @(negedge clk);
    @(negedge clk);
    check("R8 result held", result, expB);
    check("R5 outValid idle", VL'(outValid), '0);
    check("R5 outUndef idle", VL'(outUndef), '0);

    // R5: back-to-back requests
    a = genVec(32'h55); b = genVec(32'h66);
    @(negedge clk);
    sizeSel = 2'b10; qMode = 1'b0; upperHalf = 1'b0; srcA = a; srcB = b; inValid = 1'b1;
    @(negedge clk);
    check("R5 b2b first", result, model(a, b, VL, 32, 1'b0));
    upperHalf = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R5 b2b second", result, model(a, b, VL, 32, 1'b1));
    check("R5 b2b valid", VL'(outValid), VL'(1'b1));

    // R7: reset mid-run clears state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R7 result after reset", result, '0);
    check("R7 valid after reset", VL'(outValid), '0);
    rstN = 1'b1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule